// File: doc/BRIEF.md
# Stream Packet Memory Command Decoder

This block is a slave on a 32-bit word streaming bus. Packets arrive one word per enable strobe, with the final word flagged by an end-of-packet strobe. The block decodes each packet and turns it into word-addressed requests on a simple synchronous memory port. The port has a request/ready handshake and returns read data one cycle after a read is accepted.

Every packet starts with a header word. Bit 31 of the header picks the access kind. Bits 27:0 give the start word address. A write packet carries its data inline after the header, and each data word goes to the next word address. A read packet carries a second header word, whose bits 23:0 give a word count. The block then requests the outgoing stream, issues the reads while it holds the grant, and sends the read results back as a framed reply packet. While a reply is being produced, or while the memory cannot take a write, the block raises busy to hold off the upstream source.

Top module: `pkt_mem_cmd`

## Requirements
- R1: During and right after reset, in_busy_o, mem_req_o, out_req_o, out_en_o and out_eop_o are all low.
- R2: A header with bit 31 = 1 starts a write. Each following data word is written with mem_we_o = 1 and mem_wdata_o equal to the word. The first word goes to the address in header bits 27:0, and each later word goes to the address one higher.
- R3: The data word that carries end-of-packet ends a write packet. The next accepted word is decoded as a new header.
- R4: A write header that itself carries end-of-packet performs no memory access. The block then waits for a new header.
- R5: A header with bit 31 = 0 starts a read. Bits 23:0 of the following word give N. Exactly N reads (mem_we_o = 0) are issued at consecutive word addresses from the header address.
- R6: Each read result is driven on out_data_o with out_en_o in the cycle after the read is accepted. Results come in request order, and out_eop_o is high only on the Nth word.
- R7: A read count of zero causes no memory access and no reply, out_req_o stays low, and the block returns to waiting for a header.
- R8: Address stepping wraps modulo 2^28, so the word after address 0xFFFFFFF goes to address 0.
- R9: in_busy_o is high from the acceptance of a nonzero read count until the last reply word. It is also high during a write packet whenever mem_ready_i is low. A word presented while in_busy_o is high is ignored.
- R10: out_req_o is high from the acceptance of a nonzero read count through the last reply word. Reads are issued only while out_grant_i is high.
- R11: A read header that carries end-of-packet is dropped with no memory access. The block then waits for a new header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_en_i | input | 1 | Input word strobe |
| in_eop_i | input | 1 | Input end-of-packet |
| in_data_i | input | 32 | Input word |
| in_busy_o | output | 1 | Hold off the input source |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 28 | Word address |
| mem_wdata_o | output | 32 | Write data |
| mem_ready_i | input | 1 | Memory accepts the request this cycle |
| mem_rdata_i | input | 32 | Read data, one cycle after an accepted read |
| out_req_o | output | 1 | Request for the outgoing stream |
| out_grant_i | input | 1 | Outgoing stream granted |
| out_en_o | output | 1 | Outgoing word strobe |
| out_eop_o | output | 1 | Outgoing end-of-packet |
| out_data_o | output | 32 | Outgoing word |

## Verification
The bench attacks the degenerate packets: a write header with end-of-packet, a read header with end-of-packet, and a read count of zero. A decoder that mishandled any of these would emit a stray memory access, or would stay stuck treating the next header as data. A write started at the top address checks the wrap; a design that carried into bit 28 or saturated would write the second word to the wrong place. Holding the grant low checks that no read slips out early and that busy and request stay up. A memory stall during a write, with a word forced onto the input while busy is high, checks that the word is dropped and not written or counted twice. Longer reads check the order of the reply words and that the end-of-packet mark sits only on the last word.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [2:0] {
    ST_HDR,
    ST_WDATA,
    ST_RCNT,
    ST_RRUN,
    ST_RLAST
  } pmc_state_e;
endpackage

// File: rtl/pmc_addr_gen.sv
module pmc_addr_gen #(
  parameter int ADDR_W = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_o <= '0;
    else if (load_i) addr_o <= load_val_i;
    else if (step_i) addr_o <= addr_o + ONE;  // natural wrap
  end

  a_r8_addr_wraps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> addr_o == ADDR_W'($past(addr_o) + ONE));
endmodule

// File: rtl/pmc_len_cnt.sv
module pmc_len_cnt #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - ONE;
  end

  assign last_o = (cnt_q == ONE);

  a_r5_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> cnt_q != '0);
endmodule

// File: rtl/pmc_reply.sv
module pmc_reply #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic              last_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              en_o,
  output logic              eop_o,
  output logic [DATA_W-1:0] data_o
);
  logic pend_q, last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      pend_q <= issue_i;
      last_q <= issue_i && last_i;
    end
  end

  assign en_o   = pend_q;
  assign eop_o  = pend_q && last_q;
  assign data_o = pend_q ? rdata_i : '0;

  a_r6_eop_on_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |-> en_o);
  a_r6_word_after_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |=> en_o);
endmodule

// File: rtl/pkt_mem_cmd.sv
module pkt_mem_cmd
  import pmc_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 28,
  parameter int CNT_W   = 24,
  parameter int ACC_BIT = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_en_i,
  input  logic              in_eop_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              in_busy_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              out_req_o,
  input  logic              out_grant_i,
  output logic              out_en_o,
  output logic              out_eop_o,
  output logic [DATA_W-1:0] out_data_o
);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  pmc_state_e st_q, st_d;
  logic acc, is_wr_hdr, cnt_zero;
  logic wr_fire, rd_fire, len_last;
  logic addr_load, len_load;

  assign in_busy_o = (st_q == ST_RRUN) || (st_q == ST_RLAST) ||
                     ((st_q == ST_WDATA) && !mem_ready_i);
  assign acc       = in_en_i && !in_busy_o;
  assign is_wr_hdr = in_data_i[ACC_BIT];
  assign cnt_zero  = (in_data_i[CNT_W-1:0] == CNT_ZERO);

  assign wr_fire = (st_q == ST_WDATA) && in_en_i && mem_ready_i;
  assign rd_fire = (st_q == ST_RRUN) && out_grant_i && mem_ready_i;

  assign addr_load = (st_q == ST_HDR) && acc;
  assign len_load  = (st_q == ST_RCNT) && acc;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_HDR:   if (acc && !in_eop_i) st_d = is_wr_hdr ? ST_WDATA : ST_RCNT;
      ST_WDATA: if (acc && in_eop_i) st_d = ST_HDR;
      ST_RCNT:  if (acc) st_d = cnt_zero ? ST_HDR : ST_RRUN;
      ST_RRUN:  if (rd_fire && len_last) st_d = ST_RLAST;
      ST_RLAST: st_d = ST_HDR;
      default:  st_d = ST_HDR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_HDR;
    else         st_q <= st_d;
  end

  pmc_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (addr_load),
    .load_val_i (in_data_i[ADDR_W-1:0]),
    .step_i     (wr_fire || rd_fire),
    .addr_o     (mem_addr_o)
  );

  pmc_len_cnt #(.CNT_W(CNT_W)) u_len (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (len_load),
    .load_val_i (in_data_i[CNT_W-1:0]),
    .dec_i      (rd_fire),
    .last_o     (len_last)
  );

  pmc_reply #(.DATA_W(DATA_W)) u_reply (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .issue_i (rd_fire),
    .last_i  (len_last),
    .rdata_i (mem_rdata_i),
    .en_o    (out_en_o),
    .eop_o   (out_eop_o),
    .data_o  (out_data_o)
  );

  assign mem_req_o   = ((st_q == ST_WDATA) && in_en_i) || ((st_q == ST_RRUN) && out_grant_i);
  assign mem_we_o    = (st_q == ST_WDATA);
  assign mem_wdata_o = in_data_i;
  assign out_req_o   = (st_q == ST_RRUN) || (st_q == ST_RLAST);

  a_r10_read_needs_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> out_grant_i);
  a_r10_word_under_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_en_o |-> out_req_o);
  a_r9_busy_in_reply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_en_o |-> in_busy_o);
  a_r2_write_from_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> in_en_i);
  a_r6_eop_ends_reply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_eop_o |=> !out_req_o);
endmodule

// File: tb/sim_pkt_mem_cmd.sv
`timescale 1ns/1ps
module sim_pkt_mem_cmd;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_en = 1'b0, in_eop = 1'b0;
  logic [31:0] in_data = '0;
  logic in_busy, mem_req, mem_we, mem_ready = 1'b1;
  logic [27:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = '0;
  logic out_req, out_grant, gnt_en = 1'b1, out_en, out_eop;
  logic [31:0] out_data;

  int n_chk = 0, n_bad = 0;
  logic [31:0] mem [64];
  int wn = 0, rn = 0, req_seen = 0;
  logic [27:0] la [256];
  logic [31:0] ld [256];
  logic        lw [256];
  logic [31:0] rd [256];
  logic        re [256];

  always #4 clk = ~clk;
  assign out_grant = gnt_en && out_req;

  pkt_mem_cmd u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_en_i(in_en), .in_eop_i(in_eop), .in_data_i(in_data),
    .in_busy_o(in_busy), .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata),
    .out_req_o(out_req), .out_grant_i(out_grant), .out_en_o(out_en), .out_eop_o(out_eop),
    .out_data_o(out_data)
  );

  always @(posedge clk) begin
    if (mem_req && mem_ready) begin
      if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[5:0]];
    end
  end

  always @(negedge clk) begin
    if (rst_n && mem_req && mem_ready && wn < 256) begin
      la[wn] = mem_addr; ld[wn] = mem_we ? mem_wdata : 32'h0; lw[wn] = mem_we; wn++;
    end
    if (rst_n && out_en && rn < 256) begin
      rd[rn] = out_data; re[rn] = out_eop; rn++;
    end
    if (rst_n && out_req) req_seen++;
  end

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic send_word(input logic [31:0] d, input logic eop);
    step();
    while (in_busy) step();
    in_en = 1'b1; in_data = d; in_eop = eop;
    step();
    in_en = 1'b0; in_eop = 1'b0; in_data = '0;
  endtask

  task automatic wait_reply();
    for (int i = 0; i < 400 && out_req; i++) step();
    step(); step();
  endtask

  task automatic do_read(input logic [27:0] a, input int n);
    send_word({4'h0, a}, 1'b0);
    send_word({8'h0, 24'(n)}, 1'b1);
    wait_reply();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!in_busy && !mem_req && !out_req && !out_en && !out_eop, "R1 idle outputs in reset",
        {in_busy, mem_req, out_req, out_en, out_eop}, 0);
    step(); rst_n = 1'b1; step();
    @(negedge clk);
    chk(!in_busy && !mem_req && !out_req && !out_en, "R1 idle outputs after reset",
        {in_busy, mem_req, out_req, out_en}, 0);
  endtask

  task automatic t_write_read();
    int w0 = wn, r0 = rn;
    send_word({4'h8, 28'h10}, 1'b0);
    send_word(32'h1111_0001, 1'b0);
    send_word(32'h2222_0002, 1'b0);
    send_word(32'h3333_0003, 1'b1);
    chk(wn - w0 == 3, "R2 write count", 64'(wn - w0), 3);
    for (int k = 0; k < 3; k++) begin
      chk(la[w0+k] == 28'h10 + 28'(k) && lw[w0+k], "R2 write address", la[w0+k], 28'h10 + 28'(k));
      chk(ld[w0+k] == {16'(k+1) * 16'h1111, 16'(k+1)}, "R2 write data", ld[w0+k], {16'(k+1) * 16'h1111, 16'(k+1)});
    end
    do_read(28'h10, 3);
    chk(wn - w0 == 6, "R3 R5 read count after write", 64'(wn - w0), 6);
    for (int k = 0; k < 3; k++) begin
      chk(la[w0+3+k] == 28'h10 + 28'(k) && !lw[w0+3+k], "R5 read address", la[w0+3+k], 28'h10 + 28'(k));
      chk(rd[r0+k] == {16'(k+1) * 16'h1111, 16'(k+1)}, "R6 reply data in order", rd[r0+k], {16'(k+1) * 16'h1111, 16'(k+1)});
      chk(re[r0+k] == (k == 2), "R6 eop on last only", re[r0+k], k == 2);
    end
  endtask

  task automatic t_empty_write();
    int w0 = wn, r0 = rn;
    send_word({4'h8, 28'h20}, 1'b1);
    step(); step();
    chk(wn == w0, "R4 no access on header-only write", 64'(wn - w0), 0);
    do_read(28'h21, 1);
    chk(wn - w0 == 1 && la[w0] == 28'h21 && !lw[w0], "R4 next header decoded as read", la[w0], 28'h21);
    chk(rn - r0 == 1 && rd[r0] == (32'hA500_0000 | 32'h21) && re[r0], "R4 reply after empty write",
        rd[r0], 32'hA500_0021);
  endtask

  task automatic t_zero_count();
    int w0 = wn, r0 = rn, q0 = req_seen;
    do_read(28'h5, 0);
    chk(wn == w0 && rn == r0, "R7 no access on zero count", 64'(wn - w0 + rn - r0), 0);
    chk(req_seen == q0, "R7 out_req stays low", 64'(req_seen - q0), 0);
    @(negedge clk);
    chk(!in_busy, "R7 not busy after zero count", in_busy, 0);
  endtask

  task automatic t_wrap();
    int w0 = wn, r0 = rn;
    send_word({4'hF, 28'hFFF_FFFF}, 1'b0);
    send_word(32'hCAFE_0000, 1'b0);
    send_word(32'hCAFE_0001, 1'b1);
    chk(la[w0] == 28'hFFF_FFFF, "R8 first write at top", la[w0], 28'hFFF_FFFF);
    chk(la[w0+1] == 28'h0, "R8 wrap to zero", la[w0+1], 0);
    do_read(28'hFFF_FFFF, 2);
    chk(la[w0+3] == 28'h0 && !lw[w0+3], "R8 read wraps", la[w0+3], 0);
    chk(rd[r0] == 32'hCAFE_0000 && rd[r0+1] == 32'hCAFE_0001, "R8 wrapped data",
        {rd[r0], rd[r0+1]}, {32'hCAFE_0000, 32'hCAFE_0001});
  endtask

  task automatic t_grant_hold();
    int w0, r0;
    gnt_en = 1'b0;
    send_word({4'h0, 28'h30}, 1'b0);
    send_word({8'h0, 24'd2}, 1'b1);
    w0 = wn; r0 = rn;
    for (int i = 0; i < 5; i++) step();
    @(negedge clk);
    chk(wn == w0 && rn == r0, "R10 no read without grant", 64'(wn - w0), 0);
    chk(out_req, "R10 request held", out_req, 1);
    chk(in_busy, "R9 busy while reply pending", in_busy, 1);
    gnt_en = 1'b1;
    wait_reply();
    chk(wn - w0 == 2 && la[w0] == 28'h30 && la[w0+1] == 28'h31, "R10 reads after grant",
        {la[w0], la[w0+1]}, {28'h30, 28'h31});
    chk(rn - r0 == 2 && !re[r0] && re[r0+1], "R6 eop position after grant", {re[r0], re[r0+1]}, 2'b01);
    chk(rd[r0+1] == 32'hA500_0031, "R6 reply data after grant", rd[r0+1], 32'hA500_0031);
  endtask

  task automatic t_ready_stall();
    int w0;
    send_word({4'h8, 28'h8}, 1'b0);
    mem_ready = 1'b0;
    @(negedge clk);
    chk(in_busy, "R9 busy while memory stalls write", in_busy, 1);
    w0 = wn;
    step();
    in_en = 1'b1; in_data = 32'hDEAD_BEEF;
    step();
    in_en = 1'b0; in_data = '0;
    chk(wn == w0, "R9 word during busy ignored", 64'(wn - w0), 0);
    mem_ready = 1'b1;
    send_word(32'h0BAD_F00D, 1'b1);
    chk(wn - w0 == 1 && la[w0] == 28'h8 && ld[w0] == 32'h0BAD_F00D, "R9 write after stall",
        ld[w0], 32'h0BAD_F00D);
  endtask

  task automatic t_read_hdr_eop();
    int w0 = wn;
    send_word({4'h0, 28'h12}, 1'b1);
    step();
    chk(wn == w0, "R11 read header with eop dropped", 64'(wn - w0), 0);
    send_word({4'h8, 28'h2A}, 1'b0);
    send_word(32'h5555_AAAA, 1'b1);
    chk(wn - w0 == 1 && lw[w0] && la[w0] == 28'h2A, "R11 next header decoded", la[w0], 28'h2A);
  endtask

  task automatic t_long_read();
    int r0 = rn;
    do_read(28'h38, 5);
    chk(rn - r0 == 5, "R5 long read count", 64'(rn - r0), 5);
    for (int k = 0; k < 5; k++) begin
      chk(rd[r0+k] == (32'hA500_0000 | 32'(56 + k)), "R6 long read order", rd[r0+k], 32'hA500_0000 | 32'(56 + k));
      chk(re[r0+k] == (k == 4), "R6 long read eop", re[r0+k], k == 4);
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'hA500_0000 | 32'(i);
    t_reset();
    t_write_read();
    t_empty_write();
    t_zero_count();
    t_wrap();
    t_grant_hold();
    t_ready_stall();
    t_read_hdr_eop();
    t_long_read();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule